// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder-Subtractor

This unit adds or subtracts two 32-bit single-precision floating-point words over a fixed four-cycle sequence. A word holds a sign bit in bit 31 (1 means negative), an 8-bit exponent in bits 30:23 with a bias of 127, and a 23-bit fraction in bits 22:0. The fraction stores the bits after an implicit leading 1, which it does not store. A one-cycle `start` pulse loads both operands and the `sub` select. Exactly four clock edges later, `done` pulses for one cycle. The result word and two exception flags then stay steady until the next completion.

The datapath has four steps. First it classifies each operand and routes zero, infinity and invalid encodings around the arithmetic. Next it orders the operands by magnitude and right-shifts the smaller significand by the exponent difference. It then adds or subtracts the significands. Finally, a combinational leading-zero counter drives a barrel shifter that restores the implicit 1 and lowers the exponent. Rounding is by truncation only. An exponent that leaves the representable range, or an undefined operation, stops the result: the unit returns a zero word and raises a flag instead of a saturated value.

Top module: `fpas_unit`

## Requirements
- R1: After reset, `done`, `result`, `exc_range` and `exc_invalid` are all zero. A `start` sampled high while the unit is idle is accepted. `done` is high for exactly one cycle, right after the fourth rising edge counted from the accepting edge. `result` and the flags change only in the cycle in which `done` is high.
- R2: A `start` sampled while an operation is in progress is ignored. It produces no extra `done` and does not alter the operation in progress.
- R3: With `sub` = 0, operands of equal sign add their significands (implicit 1 included). A carry out of the 24-bit significand shifts the sum right by one and raises the exponent by one. Result fractions are truncated.
- R4: `sub` = 1 computes `opa - opb` by inverting the sign of `opb` and then adding. When the effective signs differ, the smaller magnitude is subtracted from the larger, and the result takes the sign of the larger. The smaller significand is first right-shifted by the exponent difference, and bits shifted past bit 0 are discarded.
- R5: A difference whose leading 1 sits below bit 23 is shifted left until that bit reaches bit 23. The exponent is lowered by the same shift count.
- R6: An operand with exponent field 0, whatever its fraction, is zero. It bypasses the arithmetic: zero with a nonzero operand returns that operand with its effective sign. Two zeros, or an exact cancellation, give +0 (word 0x00000000).
- R7: An operand with exponent field 255 and fraction 0 is infinity. Infinity combined with a finite or zero operand returns that infinity with its effective sign. Two infinities of the same effective sign return that infinity.
- R8: Two infinities of opposite effective sign, or any operand with exponent field 255 and a nonzero fraction, set `exc_invalid` and return a zero word.
- R9: A normalized result exponent of 255 or more, or of 0 or less, sets `exc_range` and returns a zero word.
- R10: At most one flag is high at a time. A completion without an exception clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (accepted when idle) |
| sub | input | 1 | 0 = add, 1 = subtract `opb` from `opa` |
| opa | input | 32 | First operand, single-precision |
| opb | input | 32 | Second operand, single-precision |
| done | output | 1 | One-cycle completion strobe |
| result | output | 32 | Result word, held between completions |
| exc_range | output | 1 | Exponent out of range on last completion |
| exc_invalid | output | 1 | Undefined operation on last completion |

## Verification
On every cycle the assertions check several timing and output properties. They confirm that each `done` comes exactly four edges after an accepted start, and that a start arriving while busy never restarts the sequence. They confirm that outputs move only with `done`, that a set flag always comes with a zero word, that the flags never overlap, and that no negative zero appears. Whether the numeric result is right depends on the operand values, so only the bench can show it. It sweeps operands that cover exponent gaps of 0, 23, 24 and more, carries, deep cancellation, zeros with stray fraction bits, infinities and invalid encodings. Each result is compared against an integer model of the requirements.

// File: rtl/fpas_pkg.sv
`timescale 1ns/1ps
package fpas_pkg;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int RAW_W   = SIG_W + 1;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam int LZ_W    = $clog2(RAW_W + 1);
    localparam int XEXP_W  = EXP_W + 2;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_SUM   = 2'd2,
        ST_NORM  = 2'd3
    } state_e;

    // Operands after classification and alignment
    typedef struct packed {
        logic             bypass;
        logic             invalid;
        fp_t              bypass_val;
        logic             sign;
        logic             eff_sub;
        logic [EXP_W-1:0] exp;
        logic [SIG_W-1:0] sig_hi;
        logic [SIG_W-1:0] sig_lo;
    } align_t;

    // Raw significand result awaiting normalization
    typedef struct packed {
        logic             bypass;
        logic             invalid;
        fp_t              bypass_val;
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [RAW_W-1:0] raw;
    } sum_t;

    function automatic logic fp_is_zero(input fp_t x);
        return x.exp == '0;
    endfunction

    function automatic logic fp_is_inf(input fp_t x);
        return (x.exp == '1) && (x.frac == '0);
    endfunction

    function automatic logic fp_is_nan(input fp_t x);
        return (x.exp == '1) && (x.frac != '0);
    endfunction
endpackage

// File: rtl/fpas_align.sv
`timescale 1ns/1ps
module fpas_align
    import fpas_pkg::*;
(
    input  fp_t    a,
    input  fp_t    b,
    input  logic   sub,
    output align_t o
);
    fp_t               bx;
    logic              a_ge;
    logic              s_hi;
    logic [EXP_W-1:0]  e_hi, e_lo, gap;
    logic [FRAC_W-1:0] f_hi, f_lo;

    always_comb begin
        bx      = b;
        bx.sign = b.sign ^ sub;
        a_ge    = {a.exp, a.frac} >= {b.exp, b.frac};
        s_hi    = a_ge ? a.sign : bx.sign;
        e_hi    = a_ge ? a.exp  : b.exp;
        f_hi    = a_ge ? a.frac : b.frac;
        e_lo    = a_ge ? b.exp  : a.exp;
        f_lo    = a_ge ? b.frac : a.frac;
        gap     = e_hi - e_lo;

        o = '0;
        if (fp_is_nan(a) || fp_is_nan(b)) begin
            o.bypass  = 1'b1;
            o.invalid = 1'b1;
        end else if (fp_is_inf(a) && fp_is_inf(b)) begin
            o.bypass = 1'b1;
            if (a.sign != bx.sign) o.invalid    = 1'b1;
            else                   o.bypass_val = a;
        end else if (fp_is_inf(a)) begin
            o.bypass     = 1'b1;
            o.bypass_val = a;
        end else if (fp_is_inf(b)) begin
            o.bypass     = 1'b1;
            o.bypass_val = bx;
        end else if (fp_is_zero(a) && fp_is_zero(b)) begin
            o.bypass = 1'b1;
        end else if (fp_is_zero(a)) begin
            o.bypass     = 1'b1;
            o.bypass_val = bx;
        end else if (fp_is_zero(b)) begin
            o.bypass     = 1'b1;
            o.bypass_val = a;
        end else begin
            o.sign    = s_hi;
            o.eff_sub = a.sign ^ bx.sign;
            o.exp     = e_hi;
            o.sig_hi  = {1'b1, f_hi};
            o.sig_lo  = {1'b1, f_lo} >> gap;
        end
    end
endmodule

// File: rtl/fpas_lzc.sv
`timescale 1ns/1ps
module fpas_lzc #(
    parameter int W  = 25,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  din,
    output logic [CW-1:0] count
);
    // Highest set bit wins because later iterations overwrite earlier ones
    always_comb begin
        count = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (din[i]) count = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/fpas_shl.sv
`timescale 1ns/1ps
module fpas_shl #(
    parameter int W  = 25,
    parameter int SW = 5
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stg [SW+1];

    assign stg[0] = din;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        assign stg[k+1] = amt[k] ? (stg[k] << (2 ** k)) : stg[k];
    end

    assign dout = stg[SW];
endmodule

// File: rtl/fpas_norm.sv
`timescale 1ns/1ps
module fpas_norm
    import fpas_pkg::*;
(
    input  sum_t s,
    output fp_t  res,
    output logic rng_err,
    output logic inv_err
);
    logic [LZ_W-1:0]          lz;
    logic [LZ_W-1:0]          shamt;
    logic [RAW_W-1:0]         shifted;
    logic signed [XEXP_W-1:0] xe;

    fpas_lzc #(.W(RAW_W), .CW(LZ_W)) u_lzc (
        .din   (s.raw),
        .count (lz)
    );

    assign shamt = (lz == '0) ? '0 : lz - LZ_W'(1);

    fpas_shl #(.W(RAW_W), .SW(LZ_W)) u_shl (
        .din  (s.raw),
        .amt  (shamt),
        .dout (shifted)
    );

    always_comb begin
        xe      = $signed({2'b00, s.exp} + XEXP_W'(1) - XEXP_W'(lz));
        res     = '0;
        rng_err = 1'b0;
        inv_err = 1'b0;
        if (s.bypass) begin
            inv_err = s.invalid;
            if (!s.invalid) res = s.bypass_val;
        end else if (s.raw == '0) begin
            res = '0;
        end else if (xe >= $signed(XEXP_W'(EXP_MAX)) || xe <= $signed(XEXP_W'(0))) begin
            rng_err = 1'b1;
        end else begin
            res.sign = s.sign;
            res.exp  = xe[EXP_W-1:0];
            res.frac = (lz == '0) ? s.raw[SIG_W-1:1] : shifted[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/fpas_unit.sv
`timescale 1ns/1ps
module fpas_unit
    import fpas_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              sub,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    output logic              done,
    output logic [WORD_W-1:0] result,
    output logic              exc_range,
    output logic              exc_invalid
);
    state_e state;
    fp_t    opa_q, opb_q;
    logic   sub_q;
    align_t align_w, align_q;
    sum_t   sum_w, sum_q;
    fp_t    norm_res;
    logic   norm_rng, norm_inv;

    fpas_align u_align (
        .a   (opa_q),
        .b   (opb_q),
        .sub (sub_q),
        .o   (align_w)
    );

    always_comb begin
        sum_w.bypass     = align_q.bypass;
        sum_w.invalid    = align_q.invalid;
        sum_w.bypass_val = align_q.bypass_val;
        sum_w.sign       = align_q.sign;
        sum_w.exp        = align_q.exp;
        sum_w.raw        = align_q.eff_sub
                         ? ({1'b0, align_q.sig_hi} - {1'b0, align_q.sig_lo})
                         : ({1'b0, align_q.sig_hi} + {1'b0, align_q.sig_lo});
    end

    fpas_norm u_norm (
        .s       (sum_q),
        .res     (norm_res),
        .rng_err (norm_rng),
        .inv_err (norm_inv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            opa_q       <= '0;
            opb_q       <= '0;
            sub_q       <= 1'b0;
            align_q     <= '0;
            sum_q       <= '0;
            done        <= 1'b0;
            result      <= '0;
            exc_range   <= 1'b0;
            exc_invalid <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        opa_q <= opa;
                        opb_q <= opb;
                        sub_q <= sub;
                        state <= ST_ALIGN;
                    end
                end
                ST_ALIGN: begin
                    align_q <= align_w;
                    state   <= ST_SUM;
                end
                ST_SUM: begin
                    sum_q <= sum_w;
                    state <= ST_NORM;
                end
                ST_NORM: begin
                    result      <= norm_res;
                    exc_range   <= norm_rng;
                    exc_invalid <= norm_inv;
                    done        <= 1'b1;
                    state       <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fpas_unit_chk.sv
`timescale 1ns/1ps
module fpas_unit_chk
    import fpas_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              done,
    input logic [WORD_W-1:0] result,
    input logic              exc_range,
    input logic              exc_invalid,
    input state_e            state
);
    logic [3:0] acc_hist;

    always_ff @(posedge clk) begin
        if (rst) acc_hist <= '0;
        else     acc_hist <= {acc_hist[2:0], start && (state == ST_IDLE)};
    end

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        done == acc_hist[3]);                                              // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                   // R1
    AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$stable({result, exc_range, exc_invalid}) |-> done);              // R1
    AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (start && state != ST_IDLE) |=> state != ST_ALIGN);                // R2
    AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (rst)
        (result[WORD_W-2:0] == '0) |-> !result[WORD_W-1]);                // R6
    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (rst)
        exc_invalid |-> (result == '0));                                  // R8
    AST_RANGE_ZERO: assert property (@(posedge clk) disable iff (rst)
        exc_range |-> (result == '0));                                    // R9
    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
        $onehot0({exc_range, exc_invalid}));                               // R10
endmodule

bind fpas_unit fpas_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .done        (done),
    .result      (result),
    .exc_range   (exc_range),
    .exc_invalid (exc_invalid),
    .state       (state)
);

// File: tb/fpas_unit_test.sv
`timescale 1ns/1ps
module fpas_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        sub = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        done;
    logic [31:0] result;
    logic        exc_range;
    logic        exc_invalid;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    fpas_unit uut (
        .clk(clk), .rst(rst), .start(start), .sub(sub), .opa(opa), .opb(opb),
        .done(done), .result(result), .exc_range(exc_range), .exc_invalid(exc_invalid)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Returns {range, invalid, word} built from the requirements
    function automatic logic [33:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic s, output string tag);
        logic   sa, sbe, sgn, a_big;
        int     ea, eb, e, d;
        longint fa, fb, mb, ms, v;
        sa  = a[31];
        sbe = b[31] ^ s;
        ea  = int'(a[30:23]);
        eb  = int'(b[30:23]);
        fa  = longint'(a[22:0]);
        fb  = longint'(b[22:0]);
        if ((ea == 255 && fa != 0) || (eb == 255 && fb != 0)) begin
            tag = "R8"; return {2'b01, 32'h0};
        end
        if (ea == 255 && eb == 255) begin
            if (sa != sbe) begin tag = "R8"; return {2'b01, 32'h0}; end
            tag = "R7"; return {2'b00, sa, 8'hff, 23'h0};
        end
        if (ea == 255) begin tag = "R7"; return {2'b00, a}; end
        if (eb == 255) begin tag = "R7"; return {2'b00, sbe, b[30:0]}; end
        if (ea == 0 && eb == 0) begin tag = "R6"; return 34'h0; end
        if (ea == 0) begin tag = "R6"; return {2'b00, sbe, b[30:0]}; end
        if (eb == 0) begin tag = "R6"; return {2'b00, a}; end
        a_big = a[30:0] >= b[30:0];
        sgn = a_big ? sa : sbe;
        e   = a_big ? ea : eb;
        d   = a_big ? ea - eb : eb - ea;
        mb  = (longint'(1) << 23) + (a_big ? fa : fb);
        ms  = ((longint'(1) << 23) + (a_big ? fb : fa)) >> d;
        tag = (sa == sbe) ? "R3" : "R4";
        v   = (sa == sbe) ? mb + ms : mb - ms;
        if (v == 0) begin tag = "R6"; return 34'h0; end
        if (v >= (longint'(1) << 24)) begin v = v >> 1; e = e + 1; end
        while (v < (longint'(1) << 23)) begin v = v << 1; e = e - 1; tag = "R5"; end
        if (e >= 255 || e <= 0) begin tag = "R9"; return {2'b10, 32'h0}; end
        return {2'b00, sgn, 8'(e), v[22:0]};
    endfunction

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic s,
                          output logic [33:0] got, output logic lat_ok);
        @(negedge clk);
        start = 1'b1; opa = a; opb = b; sub = s;
        @(negedge clk);
        start = 1'b0;
        lat_ok = !done;
        repeat (2) begin
            @(negedge clk);
            lat_ok = lat_ok && !done;
        end
        @(negedge clk);
        lat_ok = lat_ok && done;
        got = {exc_range, exc_invalid, result};
    endtask

    task automatic op_and_check(input logic [31:0] a, input logic [31:0] b, input logic s);
        logic [33:0] got, exp;
        logic        lat;
        string       tag;
        exp = model(a, b, s, tag);
        run_op(a, b, s, got, lat);
        check("R1 latency", 64'(lat), 64'(1'b1));
        check(tag, 64'(got), 64'(exp));
        if (exp[33:32] == 2'b00) check("R10 flags clear", 64'(got[33:32]), 64'h0);
    endtask

    initial begin
        repeat (10_000) @(posedge clk);
        repeat (190_000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [33:0] got;
        logic        lat;
        int          exps [10] = '{0, 1, 2, 23, 24, 126, 127, 150, 254, 255};
        logic [22:0] fracs [4] = '{23'h0, 23'h1, 23'h400000, 23'h7fffff};

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset", {29'h0, done, result, exc_range, exc_invalid}, 64'h0);

        // Directed values checked against hand-worked constants
        run_op(32'h3FC00000, 32'h3FE00000, 1'b0, got, lat);
        check("R3 1.5+1.75", 64'(got), 64'h040500000);
        run_op(32'h3FC00000, 32'h3FE00000, 1'b1, got, lat);
        check("R5 1.5-1.75", 64'(got), 64'h0BE800000);
        run_op(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, got, lat);
        check("R9 overflow", 64'(got), 64'h200000000);
        run_op(32'h7F800000, 32'h7F800000, 1'b1, got, lat);
        check("R8 inf-inf", 64'(got), 64'h100000000);
        run_op(32'h3F800000, 32'h3F800000, 1'b0, got, lat);
        check("R10 cleared after exception", 64'(got), 64'h040000000);
        run_op(32'hC0000000, 32'hC0000000, 1'b1, got, lat);
        check("R6 cancel to +0", 64'(got), 64'h0);
        run_op(32'h00000000, 32'h40500000, 1'b1, got, lat);
        check("R6 zero minus x", 64'(got), 64'h0C0500000);
        run_op(32'hFF800000, 32'h3F800000, 1'b0, got, lat);
        check("R7 -inf plus 1", 64'(got), 64'h0FF800000);

        // R2: start held through the busy cycles with other operands
        @(negedge clk);
        start = 1'b1; opa = 32'h3F800000; opb = 32'h3F800000; sub = 1'b0;
        @(negedge clk);
        opa = 32'h40500000; opb = 32'h40500000; sub = 1'b1;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check("R2 busy start result", {31'h0, done, result}, {31'h0, 1'b1, 32'h40000000});
        lat = 1'b0;
        repeat (6) begin
            @(negedge clk);
            lat = lat || done;
        end
        check("R2 no extra done", 64'(lat), 64'h0);

        // Near-exhaustive sweep over exponent gaps, fractions and signs
        foreach (exps[ia]) foreach (fracs[ja]) foreach (exps[ib]) foreach (fracs[jb]) begin
            for (int sa = 0; sa < 2; sa++) begin
                for (int s = 0; s < 2; s++) begin
                    op_and_check({1'(sa), 8'(exps[ia]), fracs[ja]},
                                 {1'b0, 8'(exps[ib]), fracs[jb]}, 1'(s));
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule